// File: doc/BRIEF.md
# Shared interrupt and DMA priority arbiter

This block chooses which pending request a processor core services next. Each source presents a request line, a 3-bit priority level and a kind bit, which marks it as either an interrupt or a DMA transfer. Interrupts and DMA requests are compared in one common arbitration step. The step runs against the current priority level (CPL) held inside the block. A DMA request may run at a level equal to the CPL. An interrupt must rise strictly above it.

Arbitration takes place only in a cycle where the core signals the end of an instruction. It does not take place while a DMA transfer is still running. The winner is reported one cycle later as a single-cycle grant, with the source index, its level and its kind. An acknowledged interrupt raises the CPL to its own level. A DMA grant leaves the CPL unchanged. A restore input lets the core reload the CPL when it returns from an interrupt handler.

Grants are plain strobes, not a stream, so the block applies no back-pressure. A source keeps its request asserted until it sees its grant, and then drops the request itself.

Top module: `dma_irq_arbiter`

## Requirements
- R1: Levels are 3-bit unsigned values from 0 to 7, and a higher number means a higher priority. Among all eligible sources, one with the highest level wins. Source i presents its level on `req_level[3*i+2:3*i]`.
- R2: An interrupt source (`req_is_dma[i]`=0) is eligible only when its level is strictly greater than the CPL.
- R3: A DMA source (`req_is_dma[i]`=1) is eligible when its level is greater than or equal to the CPL. With CPL=0, a DMA request at level 0 is granted and an interrupt at level 0 is not.
- R4: When the best eligible level is held by both a DMA source and an interrupt source, the DMA source wins.
- R5: When the best eligible level and kind are held by several sources, the lowest source index wins.
- R6: Arbitration is evaluated only in a cycle where `instr_end`=1. The grant appears on `grant_valid` in the following cycle and lasts exactly one cycle, so there is at most one grant per strobe. Without a strobe, no grant is issued.
- R7: When `dma_busy`=1 in the strobe cycle, no grant is issued.
- R8: An interrupt grant loads the CPL with the granted level. The new CPL is visible on `cpl` in the same cycle that `grant_valid` is high.
- R9: A DMA grant leaves the CPL unchanged.
- R10: `cpl_restore_valid`=1 loads `cpl_restore_level` into the CPL at the next edge. If an interrupt is acknowledged at that same edge, the interrupt's level is loaded instead.
- R11: After reset, the CPL is 0 and `grant_valid` is 0. While `grant_valid` is 0, `grant_idx`, `grant_level` and `grant_is_dma` read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Per-source request pending |
| req_level | input | 24 | Per-source 3-bit level, source i at bits 3i+2..3i |
| req_is_dma | input | 8 | Per-source kind, 1 = DMA, 0 = interrupt |
| instr_end | input | 1 | End-of-instruction strobe from the core |
| dma_busy | input | 1 | A DMA transfer is in progress |
| cpl_restore_valid | input | 1 | Reload the CPL (return from interrupt) |
| cpl_restore_level | input | 3 | Level to reload into the CPL |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_idx | output | 3 | Index of the granted source |
| grant_level | output | 3 | Level of the granted source |
| grant_is_dma | output | 1 | 1 if the grant is a DMA transfer |
| cpl | output | 3 | Current priority level |

## Verification
The bench targets the comparison edges. The first is a request whose level equals the CPL: a design that used the wrong comparison for that kind would either grant an interrupt there or turn away a DMA request. The second is CPL=0, where only DMA can win. Directed cases also cover equal-level collisions, both DMA against interrupt and source against source. A wrong tie-break shows up there as the wrong index or the wrong kind. Further cases check that a DMA grant leaves the CPL alone, that a busy cycle or a missing strobe produces no grant, and that an interrupt acknowledge overrides a restore issued at the same edge. If any of these were wrong, the CPL would drift, or grants would appear in cycles where none is allowed.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    KIND_IRQ = 1'b0,
    KIND_DMA = 1'b1
  } req_kind_e;

  function automatic logic kind_admits(input req_kind_e kind,
                                       input logic [2:0] lvl,
                                       input logic [2:0] cur);
    if (kind == KIND_DMA) return (lvl >= cur);
    else                  return (lvl > cur);
  endfunction

endpackage

// File: rtl/arb_eligibility.sv
module arb_eligibility #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3
) (
  input  logic [N_SRC-1:0]       req_valid,
  input  logic [N_SRC*LVL_W-1:0] req_level,
  input  logic [N_SRC-1:0]       req_is_dma,
  input  logic [LVL_W-1:0]       cur_level,
  output logic [N_SRC-1:0]       eligible
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [LVL_W-1:0] lvl;
    logic             above;
    logic             equal;

    assign lvl   = req_level[g*LVL_W +: LVL_W];
    assign above = (lvl > cur_level);
    assign equal = (lvl == cur_level);
    // DMA runs at the current level; an interrupt must pre-empt it
    assign eligible[g] = req_valid[g] & (above | (equal & req_is_dma[g]));
  end

endmodule

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       eligible,
  input  logic [N_SRC*LVL_W-1:0] req_level,
  input  logic [N_SRC-1:0]       req_is_dma,
  output logic                   found,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_level,
  output req_kind_e              win_kind
);

  // Ordering key: level first, then DMA over interrupt.
  // A strict compare while scanning upward keeps the lowest index on ties.
  always_comb begin
    found     = 1'b0;
    win_idx   = '0;
    win_level = '0;
    win_kind  = KIND_IRQ;
    for (int i = 0; i < N_SRC; i++) begin
      if (eligible[i]) begin
        if (!found ||
            ({req_level[i*LVL_W +: LVL_W], req_is_dma[i]} >
             {win_level, win_kind == KIND_DMA})) begin
          found     = 1'b1;
          win_idx   = IDX_W'(i);
          win_level = req_level[i*LVL_W +: LVL_W];
          win_kind  = req_is_dma[i] ? KIND_DMA : KIND_IRQ;
        end
      end
    end
  end

endmodule

// File: rtl/arb_cpl_reg.sv
module arb_cpl_reg #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_load,
  input  logic [LVL_W-1:0] ack_level,
  input  logic             restore_valid,
  input  logic [LVL_W-1:0] restore_level,
  output logic [LVL_W-1:0] cpl
);

  always_ff @(posedge clk) begin
    if (!rst_n)             cpl <= '0;
    else if (ack_load)      cpl <= ack_level;
    else if (restore_valid) cpl <= restore_level;
  end

  AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid && !ack_load |=> cpl == $past(restore_level)); // R10
  AST_ACK_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_load |=> cpl == $past(ack_level)); // R10
  AST_CPL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_load && !restore_valid |=> $stable(cpl)); // R9

endmodule

// File: rtl/dma_irq_arbiter.sv
module dma_irq_arbiter
  import arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       req_valid,
  input  logic [N_SRC*LVL_W-1:0] req_level,
  input  logic [N_SRC-1:0]       req_is_dma,
  input  logic                   instr_end,
  input  logic                   dma_busy,
  input  logic                   cpl_restore_valid,
  input  logic [LVL_W-1:0]       cpl_restore_level,
  output logic                   grant_valid,
  output logic [IDX_W-1:0]       grant_idx,
  output logic [LVL_W-1:0]       grant_level,
  output logic                   grant_is_dma,
  output logic [LVL_W-1:0]       cpl
);

  logic [N_SRC-1:0] eligible;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_level;
  req_kind_e        win_kind;
  logic             fire;
  logic             irq_ack;

  arb_eligibility #(.N_SRC(N_SRC), .LVL_W(LVL_W)) i_elig (
    .req_valid  (req_valid),
    .req_level  (req_level),
    .req_is_dma (req_is_dma),
    .cur_level  (cpl),
    .eligible   (eligible)
  );

  arb_select #(.N_SRC(N_SRC), .LVL_W(LVL_W)) i_sel (
    .eligible   (eligible),
    .req_level  (req_level),
    .req_is_dma (req_is_dma),
    .found      (found),
    .win_idx    (win_idx),
    .win_level  (win_level),
    .win_kind   (win_kind)
  );

  // The transfer in flight cannot be interrupted, so busy blocks arbitration
  assign fire    = instr_end & ~dma_busy & found;
  assign irq_ack = fire & (win_kind == KIND_IRQ);

  arb_cpl_reg #(.LVL_W(LVL_W)) i_cpl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_load      (irq_ack),
    .ack_level     (win_level),
    .restore_valid (cpl_restore_valid),
    .restore_level (cpl_restore_level),
    .cpl           (cpl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid  <= 1'b0;
      grant_idx    <= '0;
      grant_level  <= '0;
      grant_is_dma <= 1'b0;
    end else begin
      grant_valid  <= fire;
      grant_idx    <= fire ? win_idx : '0;
      grant_level  <= fire ? win_level : '0;
      grant_is_dma <= fire & (win_kind == KIND_DMA);
    end
  end

  AST_GRANT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(instr_end) |-> !grant_valid); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_busy) |-> !grant_valid); // R7
  AST_IRQ_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_is_dma |-> grant_level > $past(cpl)); // R2
  AST_DMA_AT_OR_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && grant_is_dma |-> grant_level >= $past(cpl)); // R3
  AST_IRQ_SETS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_is_dma |-> cpl == grant_level); // R8
  AST_DMA_KEEPS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && grant_is_dma && !$past(cpl_restore_valid) |-> $stable(cpl)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant_idx == '0 && grant_level == '0 && !grant_is_dma); // R11

endmodule

// File: tb/test_dma_irq_arbiter.sv
module test_dma_irq_arbiter;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [3*N-1:0] req_level = '0;
  logic [N-1:0] req_is_dma = '0;
  logic         instr_end = 1'b0;
  logic         dma_busy = 1'b0;
  logic         cpl_restore_valid = 1'b0;
  logic [2:0]   cpl_restore_level = '0;
  logic         grant_valid;
  logic [2:0]   grant_idx;
  logic [2:0]   grant_level;
  logic         grant_is_dma;
  logic [2:0]   cpl;

  int n_checks = 0;
  int n_fails  = 0;
  logic [2:0] m_cpl = '0;

  always #5 clk = ~clk;

  dma_irq_arbiter i_dma_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_is_dma(req_is_dma), .instr_end(instr_end), .dma_busy(dma_busy),
    .cpl_restore_valid(cpl_restore_valid), .cpl_restore_level(cpl_restore_level),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_level(grant_level),
    .grant_is_dma(grant_is_dma), .cpl(cpl)
  );

  // {valid, idx, level, dma}
  function automatic logic [7:0] predict(input logic [2:0] cur);
    logic       f = 1'b0;
    logic [2:0] bi = '0, bl = '0;
    logic       bd = 1'b0;
    if (!instr_end || dma_busy) return 8'h0;
    for (int i = 0; i < N; i++) begin
      logic [2:0] l = req_level[3*i +: 3];
      logic ok = req_valid[i] && (req_is_dma[i] ? (l >= cur) : (l > cur));
      if (ok) begin
        if (!f || l > bl || (l == bl && req_is_dma[i] && !bd)) begin
          f = 1'b1; bi = 3'(i); bl = l; bd = req_is_dma[i];
        end
      end
    end
    return {f, bi, bl, bd};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs are already set away from the edge; advance one cycle and check
  task automatic step(input string tag);
    logic [7:0] e = predict(m_cpl);
    @(posedge clk);
    if (e[7] && !e[0])          m_cpl = e[3:1];
    else if (cpl_restore_valid) m_cpl = cpl_restore_level;
    #2;
    chk({tag, " grant"}, {grant_valid, grant_idx, grant_level, grant_is_dma}, e);
    chk({tag, " cpl"}, {5'b0, cpl}, {5'b0, m_cpl});
  endtask

  task automatic clr();
    req_valid = '0; req_level = '0; req_is_dma = '0;
    instr_end = 1'b0; dma_busy = 1'b0; cpl_restore_valid = 1'b0; cpl_restore_level = '0;
  endtask

  task automatic put(input int s, input logic [2:0] l, input logic d);
    req_valid[s] = 1'b1; req_level[3*s +: 3] = l; req_is_dma[s] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fails + 1, n_checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    chk("R11 reset", {grant_valid, grant_idx, grant_level, grant_is_dma, 1'b0, cpl}, 8'h0);
    rst_n = 1'b1;

    // R3: CPL=0, equal-level DMA wins, interrupt at 0 refused
    clr(); instr_end = 1'b1; put(2, 3'd0, 1'b0); put(5, 3'd0, 1'b1);
    step("R3 dma at cpl 0");
    clr(); instr_end = 1'b1; put(2, 3'd0, 1'b0);
    step("R2 irq at cpl 0");
    // R4: DMA beats interrupt at same level
    clr(); instr_end = 1'b1; put(1, 3'd4, 1'b0); put(6, 3'd4, 1'b1);
    step("R4 tie dma wins");
    // R5 / R8: lowest index among equal interrupts, CPL follows
    clr(); instr_end = 1'b1; put(5, 3'd6, 1'b0); put(3, 3'd6, 1'b0);
    step("R5 R8 low index irq");
    // R6: single cycle grant, no strobe no grant
    clr(); put(0, 3'd7, 1'b0);
    step("R6 no strobe");
    // R2: interrupt equal to CPL refused
    clr(); instr_end = 1'b1; put(4, 3'd6, 1'b0);
    step("R2 irq equal cpl");
    // R9: DMA equal to CPL granted, CPL unchanged
    clr(); instr_end = 1'b1; put(4, 3'd6, 1'b1);
    step("R9 dma keeps cpl");
    // R1: higher level wins
    clr(); instr_end = 1'b1; put(0, 3'd6, 1'b1); put(7, 3'd7, 1'b0);
    step("R1 highest level");
    // R7: busy blocks
    clr(); instr_end = 1'b1; dma_busy = 1'b1; put(0, 3'd7, 1'b1);
    step("R7 busy");
    // R10: restore, then restore colliding with interrupt
    clr(); cpl_restore_valid = 1'b1; cpl_restore_level = 3'd2;
    step("R10 restore");
    clr(); instr_end = 1'b1; cpl_restore_valid = 1'b1; cpl_restore_level = 3'd1;
    put(3, 3'd5, 1'b0);
    step("R10 ack over restore");
    clr(); cpl_restore_valid = 1'b1; cpl_restore_level = 3'd0;
    step("R10 restore zero");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      clr();
      for (int s = 0; s < N; s++) begin
        if ($urandom_range(0, 2) == 0) put(s, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      end
      instr_end         = ($urandom_range(0, 3) != 0);
      dma_busy          = ($urandom_range(0, 4) == 0);
      cpl_restore_valid = ($urandom_range(0, 6) == 0);
      cpl_restore_level = 3'($urandom_range(0, 7));
      step("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule